// File: doc/BRIEF.md
# Programmable-Order MASH Delta-Sigma Modulator

This block drives the modulus control of a fractional-N feedback divider. On every active clock edge it emits a signed division command. In fractional mode that command is the integer setting plus a noise-shaped carry pattern, so the average divide ratio comes out as the integer part plus a fractional numerator divided by 2^m. The word length m of the accumulators can be set from 16 to 24 bits. Bits above the active length are masked off, so the carry of each accumulator leaves from bit position m−1 into position m.

Two cascades are available: a second-order one built from two accumulators and a third-order one built from three. The carries of the later stages pass through a differentiating cancellation network, so only the first stage's carry adds a net average. An integer mode bypasses the noise shaping and emits the integer part alone. A disable input holds the modulator in a cleared, idle state. A polarity input selects whether the modulator runs on the rising or the falling edge of the supplied clock.

Top module: `mash_dsm`

## Requirements
- R1: While reset is asserted and after it is released, `div_cmd` reads 0 until the modulator is enabled. Reset release takes effect after two active clock edges.
- R2: When `mod_en` is 0 at an active edge, `div_cmd` becomes 0 and all accumulator and carry-delay state is cleared. A later enable therefore restarts the sequence from an all-zero state.
- R3: When enabled with `frac_mode` = 0, `div_cmd` equals `int_n` on every active edge and all modulator state is cleared.
- R4: With `frac_mode` = 1 and `third_order` = 0, `div_cmd` = N + c1 + c2 − c2' after each active edge, where c1 and c2 are the carries of stages 1 and 2 and c2' is the stage-2 carry of the previous edge. The offset from N lies in −1..+2.
- R5: With `third_order` = 1 the term c3 − 2·c3' + c3'' is added, where c3'' is the stage-3 carry from two edges back. The offset lies in −3..+4.
- R6: Active length m = 16 + `len_code`, and codes above 8 give m = 24. A stage carries when its sum reaches 2^m. Bits of `frac_k` at position m and above have no effect on the output.
- R7: On an active edge where {`third_order`,`len_code`} differs from its value at the previous active edge, all accumulator and delay state is cleared and `div_cmd` becomes `int_n`.
- R8: In second order, starting from cleared state, the sum of `div_cmd` over 2^m consecutive edges equals N·2^m + (K mod 2^m) exactly.
- R9: In third order, starting from cleared state, that sum differs from N·2^m + (K mod 2^m) by at most 1.
- R10: With `clk_inv` = 1 the modulator updates only on falling edges of `clk`, and `div_cmd` is stable across rising edges.
- R11: `div_cmd` is registered. It reflects the inputs sampled at the active edge on which it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (divider output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | 1 runs the modulator, 0 idles and clears it |
| clk_inv | input | 1 | 0: run on rising edge, 1: run on falling edge |
| frac_mode | input | 1 | 1 fractional, 0 integer-only |
| third_order | input | 1 | 1 selects the three-stage cascade, 0 the two-stage one |
| len_code | input | 4 | Accumulator length code, m = 16 + min(code, 8) |
| int_n | input | 8 | Integer part N |
| frac_k | input | 24 | Fractional numerator K |
| div_cmd | output | 10 | Signed per-cycle division command |

## Verification
Every result appears on `div_cmd` one active edge after the inputs it depends on are sampled. The exception is reset release, which needs two active edges through the synchronizer. The bench changes inputs only just after an active edge and samples 1 ns after the next active edge, whether that edge is rising or falling. At that point it compares against a behavioural model advanced at the same edge. In falling-edge mode it also samples after the intervening rising edge to confirm nothing moved. The long-run averages are summed over exactly 2^16 consecutive samples, starting at the first enabled edge after a clear.

// File: rtl/mash_dsm_pkg.sv
package mash_dsm_pkg;
  localparam int NUM_STAGES = 3;

  typedef enum logic {
    ORD_TWO   = 1'b0,
    ORD_THREE = 1'b1
  } mash_order_e;

  typedef logic [NUM_STAGES-1:0] carry_vec_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int ACC_W = 24,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [ACC_W-1:0] mask,
  input  logic [IDX_W-1:0] msb_pos,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] residue,
  output logic             carry
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q & mask} + {1'b0, din & mask};
    carry   = sum[msb_pos];
    residue = sum[ACC_W-1:0] & mask;
  end

  always_comb begin
    if (clr)      acc_d = '0;
    else if (adv) acc_d = residue;
    else          acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
  import mash_dsm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  mash_order_e        order,
  input  carry_vec_t         carries,
  output logic signed [3:0]  offset
);
  logic c2_q, c3_q, c3_qq;
  logic c2_d, c3_d, c3_dd;
  logic c3_eff;

  always_comb begin
    c3_eff = carries[2] & (order == ORD_THREE);
    offset = $signed({3'b000, carries[0]}) + $signed({3'b000, carries[1]})
           - $signed({3'b000, c2_q});
    if (order == ORD_THREE)
      offset = offset + $signed({3'b000, c3_eff}) - $signed({2'b00, c3_q, 1'b0})
             + $signed({3'b000, c3_qq});
  end

  always_comb begin
    if (clr) begin
      c2_d = 1'b0; c3_d = 1'b0; c3_dd = 1'b0;
    end else if (adv) begin
      c2_d = carries[1]; c3_d = c3_eff; c3_dd = c3_q;
    end else begin
      c2_d = c2_q; c3_d = c3_q; c3_dd = c3_qq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q <= 1'b0; c3_q <= 1'b0; c3_qq <= 1'b0;
    end else begin
      c2_q <= c2_d; c3_q <= c3_d; c3_qq <= c3_dd;
    end
  end
endmodule

// File: rtl/mash_dsm.sv
module mash_dsm
  import mash_dsm_pkg::*;
#(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 24,
  parameter int MIN_LEN = 16,
  parameter int LEN_CW  = 4,
  localparam int OUT_W  = INT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic                    clk_inv,
  input  logic                    frac_mode,
  input  logic                    third_order,
  input  logic [LEN_CW-1:0]       len_code,
  input  logic [INT_W-1:0]        int_n,
  input  logic [FRAC_W-1:0]       frac_k,
  output logic signed [OUT_W-1:0] div_cmd
);
  localparam int IDX_W    = $clog2(FRAC_W + 1);
  localparam int LEN_SPAN = FRAC_W - MIN_LEN;

  logic mod_clk;
  logic rst_meta, rst_s_n;
  assign mod_clk = clk ^ clk_inv;

  // reset: asynchronous assert, release aligned to the active edge
  always_ff @(posedge mod_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0; rst_s_n <= 1'b0;
    end else begin
      rst_meta <= 1'b1; rst_s_n <= rst_meta;
    end
  end

  mash_order_e           order;
  logic [IDX_W-1:0]      act_len;
  logic [FRAC_W-1:0]     len_mask;
  logic [LEN_CW:0]       cfg_q, cfg_d;
  logic                  cfg_chg, clr, run;

  assign order = third_order ? ORD_THREE : ORD_TWO;

  always_comb begin
    if (int'(len_code) > LEN_SPAN) act_len = IDX_W'(FRAC_W);
    else                           act_len = IDX_W'(MIN_LEN + int'(len_code));
    len_mask = {FRAC_W{1'b1}} >> (IDX_W'(FRAC_W) - act_len);
    cfg_d    = {third_order, len_code};
    cfg_chg  = (cfg_d != cfg_q);
    run      = mod_en & frac_mode & ~cfg_chg;
    clr      = ~run;
  end

  always_ff @(posedge mod_clk or negedge rst_s_n) begin
    if (!rst_s_n) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  logic [FRAC_W-1:0] res [NUM_STAGES];
  carry_vec_t        carries;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic [FRAC_W-1:0] stage_in;
    logic              stage_clr;
    if (g == 0) begin : g_first
      assign stage_in = frac_k;
    end else begin : g_next
      assign stage_in = res[g-1];
    end
    if (g >= 2) begin : g_hi
      assign stage_clr = clr | (order != ORD_THREE);
    end else begin : g_lo
      assign stage_clr = clr;
    end
    mash_acc_stage #(.ACC_W(FRAC_W), .IDX_W(IDX_W)) u_acc (
      .clk     (mod_clk),
      .rst_n   (rst_s_n),
      .clr     (stage_clr),
      .adv     (run),
      .mask    (len_mask),
      .msb_pos (act_len),
      .din     (stage_in),
      .residue (res[g]),
      .carry   (carries[g])
    );
  end

  logic signed [3:0] offset;

  mash_cancel u_cancel (
    .clk     (mod_clk),
    .rst_n   (rst_s_n),
    .clr     (clr),
    .adv     (run),
    .order   (order),
    .carries (carries),
    .offset  (offset)
  );

  logic signed [OUT_W-1:0] n_ext, off_ext, out_d;

  always_comb begin
    n_ext   = $signed({{(OUT_W-INT_W){1'b0}}, int_n});
    off_ext = $signed({{(OUT_W-4){offset[3]}}, offset});
    if (!mod_en)  out_d = '0;
    else if (run) out_d = n_ext + off_ext;
    else          out_d = n_ext;
  end

  always_ff @(posedge mod_clk or negedge rst_s_n) begin
    if (!rst_s_n) div_cmd <= '0;
    else          div_cmd <= out_d;
  end
endmodule

// File: rtl/mash_dsm_chk.sv
module mash_dsm_chk #(
  parameter int INT_W  = 8,
  parameter int OUT_W  = 10,
  parameter int LEN_CW = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    frac,
  input logic                    order3,
  input logic [LEN_CW-1:0]       len_code,
  input logic [INT_W-1:0]        int_n,
  input logic signed [OUT_W-1:0] div_cmd
);
  logic [INT_W-1:0]  n_q;
  logic [LEN_CW:0]   cfg_prev;
  logic              seen;
  logic signed [OUT_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0; cfg_prev <= '0; seen <= 1'b0;
    end else begin
      n_q <= int_n; cfg_prev <= {order3, len_code}; seen <= 1'b1;
    end
  end

  assign diff = div_cmd - $signed({{(OUT_W-INT_W){1'b0}}, n_q});

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> div_cmd == '0);

  assert_integer_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && !frac |=> diff == '0);

  assert_range_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && frac && !order3 |=> (diff >= -1 && diff <= 2));

  assert_range_three_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && frac && order3 |=> (diff >= -3 && diff <= 4));

  assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen && en && ({order3, len_code} != cfg_prev) |=> diff == '0);
endmodule

bind mash_dsm mash_dsm_chk #(.INT_W(INT_W), .OUT_W(OUT_W), .LEN_CW(LEN_CW)) u_chk (
  .clk      (mod_clk),
  .rst_n    (rst_s_n),
  .en       (mod_en),
  .frac     (frac_mode),
  .order3   (third_order),
  .len_code (len_code),
  .int_n    (int_n),
  .div_cmd  (div_cmd)
);

// File: tb/mash_dsm_bench.sv
`timescale 1ns/1ps
module mash_dsm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0, clk_inv = 1'b0, frac_mode = 1'b0, third_order = 1'b0;
  logic [3:0]  len_code = '0;
  logic [7:0]  int_n = '0;
  logic [23:0] frac_k = '0;
  logic signed [9:0] div_cmd;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int a1 = 0, a2 = 0, a3 = 0, d2 = 0, d3 = 0, dd3 = 0, prev_cfg = 0, exp_out = 0;
  string tag;

  always #2.5 clk = ~clk;

  mash_dsm u_mash_dsm (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .clk_inv(clk_inv),
    .frac_mode(frac_mode), .third_order(third_order), .len_code(len_code),
    .int_n(int_n), .frac_k(frac_k), .div_cmd(div_cmd)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 199000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 199000", cyc);
      summary();
    end
  end

  task automatic check(input string t, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: div_cmd actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per active edge
  task automatic model_edge();
    int m, msk, cfg, s, c1, c2, c3;
    m   = 16 + ((len_code > 8) ? 8 : int'(len_code));
    msk = (1 << m) - 1;
    cfg = int'(third_order) * 16 + int'(len_code);
    if (!mod_en || !frac_mode || cfg != prev_cfg) begin
      a1 = 0; a2 = 0; a3 = 0; d2 = 0; d3 = 0; dd3 = 0;
      exp_out = mod_en ? int'(int_n) : 0;
      tag = !mod_en ? "R2" : (!frac_mode ? "R3" : "R7");
    end else begin
      s = a1 + (int'(frac_k) & msk); c1 = s >> m; a1 = s & msk;
      s = a2 + a1;                   c2 = s >> m; a2 = s & msk;
      if (third_order) begin
        s = a3 + a2; c3 = s >> m; a3 = s & msk;
      end else begin
        c3 = 0; a3 = 0;
      end
      exp_out = int'(int_n) + c1 + c2 - d2;
      if (third_order) exp_out += c3 - 2 * d3 + dd3;
      d2 = c2; dd3 = third_order ? d3 : 0; d3 = c3;
      tag = third_order ? "R5" : "R4";
    end
    prev_cfg = cfg;
  endtask

  task automatic step(input string force_tag);
    if (clk_inv) @(negedge clk); else @(posedge clk);
    model_edge();
    #1;
    check((force_tag == "") ? {tag, "/R11"} : force_tag, int'(div_cmd), exp_out);
    if (clk_inv) begin
      @(posedge clk); #1;
      check("R10 stable over rising edge", int'(div_cmd), exp_out);
    end
  endtask

  initial begin
    longint sum;
    #1;
    check("R1 during reset", int'(div_cmd), 0);
    repeat (4) @(posedge clk);
    #1.2 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R1 after reset");

    // R3: integer mode
    mod_en = 1'b1; int_n = 8'd77; frac_k = 24'h00ABCD;
    for (int i = 0; i < 5; i++) step("R3 integer");
    int_n = 8'd200;
    for (int i = 0; i < 3; i++) step("R3 integer new N");

    // R4: second order, m = 16
    frac_mode = 1'b1; int_n = 8'd40; frac_k = 24'h003000;
    for (int i = 0; i < 200; i++) step("");
    // R6: upper K bits beyond m ignored
    frac_k = 24'hFF3000;
    for (int i = 0; i < 100; i++) step("R6 masked K bits");

    // R7 then R6: length change clears, m = 21
    len_code = 4'd5; frac_k = 24'h012345;
    step("R7 length change");
    for (int i = 0; i < 300; i++) step("R6 m=21");
    len_code = 4'd12; frac_k = 24'hABCDEF;
    for (int i = 0; i < 300; i++) step("R6 saturated m=24");

    // R5: third order, negative outputs with N = 0
    third_order = 1'b1; len_code = 4'd3; int_n = 8'd0; frac_k = 24'h005555;
    step("R7 order change");
    for (int i = 0; i < 500; i++) step("");

    // R2: disable mid-run and restart
    mod_en = 1'b0;
    for (int i = 0; i < 2; i++) step("R2 disabled");
    mod_en = 1'b1; int_n = 8'd100;
    for (int i = 0; i < 100; i++) step("R2 restart from clear");

    // R10: falling-edge operation
    mod_en = 1'b0;
    step("R2 idle");
    clk_inv = 1'b1;
    for (int i = 0; i < 2; i++) step("R10 idle");
    mod_en = 1'b1; frac_k = 24'h00F0F1;
    for (int i = 0; i < 200; i++) step("R10 falling-edge run");
    mod_en = 1'b0;
    step("R10 idle");
    clk_inv = 1'b0;
    for (int i = 0; i < 2; i++) step("R2 idle");

    // R8: exact mean, second order, m = 16
    third_order = 1'b0; len_code = 4'd0; int_n = 8'd40; frac_k = 24'h002B67;
    step("R2 idle");
    mod_en = 1'b1; sum = 0;
    for (int i = 0; i < 65536; i++) begin
      step("");
      sum += longint'(div_cmd);
    end
    check("R8 mean over 2^16", int'(sum - 40 * 65536), 'h2B67);

    // R9: third order mean within one
    mod_en = 1'b0; third_order = 1'b1; frac_k = 24'h009A3D;
    step("R2 idle");
    mod_en = 1'b1; sum = 0;
    for (int i = 0; i < 65536; i++) begin
      step("");
      sum += longint'(div_cmd);
    end
    sum = sum - 40 * 65536 - 'h9A3D;
    check("R9 mean deviation within 1", (sum >= -1 && sum <= 1) ? 1 : 0, 1);

    summary();
  end
endmodule